// File: doc/BRIEF.md
# Addressed Serial Segment-Data Receiver

This block is the serial input stage of a segment LCD driver. A host drives three pins: a chip-enable, a serial clock and a data line. The block samples them with the system clock. After each chip-enable assertion it collects an 8-bit address, least-significant bit first. If the address is 0x41, the bits that follow are taken as a payload made of 156 segment bits and a 4-bit control field. When chip-enable falls, the payload is copied into the registers that feed the drive logic.

The payload is right-aligned. The last bits received always land in the control field and in the highest-numbered segment positions. A host that uses only part of the panel can therefore send just the tail of the display field, and any segment it leaves out reads as off. If the address does not match, or chip-enable drops before the address is complete, the frame is dropped and the outputs keep their values.

Top module: `lcd_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released, seg_data is all zero and bias_third, seg_blank and power_save are 0.
- R2: The address is the first 8 bits of a frame, sent least-significant bit first; only the value 0x41 (wire order 1,0,0,0,0,0,1,0) lets the frame update the outputs.
- R3: A frame with any other address, including 0x82, leaves every output unchanged.
- R4: A frame whose chip-enable falls after fewer than 8 serial clock rising edges leaves every output unchanged.
- R5: In a 160-bit payload the k-th bit (k = 1..156) drives seg_data[k-1], with 1 meaning segment on. Bit 157 drives bias_third (1 = one-third bias), bit 158 drives seg_blank (1 = all segments off) and bit 159 drives power_save (1 = power saving). Bit 160 is a fixed zero and is ignored.
- R6: A payload of n < 160 bits is right-aligned: its i-th bit (i = 0..n-1) goes to frame position 160-n+i, where positions 0..155 are seg_data and 156..158 are the flags. Positions that receive no bit read 0, which includes a frame with no payload at all.
- R7: A payload longer than 160 bits keeps only its last 160 bits, placed as in R5.
- R8: Frames are received the same way whether the serial clock idles low or high while chip-enable is low. Data is sampled on the serial clock rising edge.
- R9: The outputs change only when chip-enable falls. While a transfer is in progress they hold the previous frame's values.
- R10: The outputs show a new frame at the third rising clk edge after chip-enable goes low at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pin | input | 1 | Chip-enable from host, active high, asynchronous |
| sck_pin | input | 1 | Serial clock from host, asynchronous |
| sdi_pin | input | 1 | Serial data from host, asynchronous |
| seg_data | output | 156 | Segment bits, bit k-1 holds segment k |
| bias_third | output | 1 | Bias select flag |
| seg_blank | output | 1 | All-segments-off flag |
| power_save | output | 1 | Power-saving flag |

## Verification
All three pins pass through a two-stage synchronizer, so a serial clock edge reaches the shift logic two to three clk cycles after it happens at the pin. The bench therefore holds each level for four clk cycles and changes data only while the serial clock is low. Chip-enable falling is the only event that updates the outputs, three clk edges after the pin change. The bench drives that change just after a falling clk edge, waits exactly three rising edges and samples on the next falling edge. It also samples once mid-transfer to confirm that the outputs are still holding the previous frame.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;

  localparam int unsigned SEG_COUNT  = 156;
  localparam int unsigned CTL_WIDTH  = 4;
  localparam int unsigned ADR_WIDTH  = 8;
  localparam logic [7:0]  ADR_MATCH  = 8'h41;

  typedef struct packed {
    logic save;
    logic blank;
    logic bias3;
  } ctl_t;

  // saturating increment used by the address counter
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // frame position hit by payload bit i of an n-bit payload (negative: shifted out)
  function automatic int frame_pos(int n, int i, int width);
    return width - n + i;
  endfunction

endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned N      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] dly_q;

  for (genvar g = 0; g < N; g++) begin : g_sig
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~dly_q;
  assign fall_o = ~lvl_o & dly_q;
endmodule

// File: rtl/lcdrx_frame.sv
module lcdrx_frame
  import lcdrx_pkg::*;
#(
  parameter int unsigned FRAME_W = 160,
  parameter int unsigned ADR_W   = 8,
  parameter logic [ADR_W-1:0] ADR_VAL = 8'h41
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_lvl,
  input  logic               ce_rise,
  input  logic               ce_fall,
  input  logic               sck_rise,
  input  logic               din,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o
);
  localparam int unsigned CW = $clog2(ADR_W + 1);

  logic [CW-1:0]      bit_cnt;
  logic [ADR_W-1:0]   adr_q;
  logic [FRAME_W-1:0] frame_q;
  logic               adr_done;
  logic               take_bit;

  assign adr_done = (bit_cnt == CW'(ADR_W));
  assign take_bit = ce_lvl && sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      adr_q   <= '0;
      frame_q <= '0;
    end else if (ce_rise) begin
      bit_cnt <= '0;
      adr_q   <= '0;
      frame_q <= '0;
    end else if (take_bit) begin
      bit_cnt <= CW'(sat_inc(int'(bit_cnt), ADR_W));
      if (!adr_done) adr_q   <= {din, adr_q[ADR_W-1:1]};
      else           frame_q <= {din, frame_q[FRAME_W-1:1]};
    end
  end

  assign frame_o  = frame_q;
  assign commit_o = ce_fall && adr_done && (adr_q == ADR_VAL);

  // R4
  r4_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> (bit_cnt == '0));
  // R6
  r6_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> (frame_q == '0));
  // R7
  r7_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_done && take_bit && !ce_rise) |=> adr_done);
endmodule

// File: rtl/lcdrx_regs.sv
module lcdrx_regs
  import lcdrx_pkg::*;
#(
  parameter int unsigned SEG_N   = 156,
  parameter int unsigned FRAME_W = 160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [SEG_N-1:0]   seg_o,
  output ctl_t               ctl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_o <= '0;
      ctl_o <= '0;
    end else if (commit_i) begin
      seg_o       <= frame_i[SEG_N-1:0];
      ctl_o.bias3 <= frame_i[SEG_N];
      ctl_o.blank <= frame_i[SEG_N+1];
      ctl_o.save  <= frame_i[SEG_N+2];
    end
  end

  // R9
  r9_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(seg_o) && $stable(ctl_o)));
  // R1
  r1_reset_chk: assert property (@(posedge clk)
    !rst_n |=> ((seg_o == '0) && (ctl_o == '0)));
endmodule

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx
  import lcdrx_pkg::*;
#(
  parameter int unsigned SEG_N     = SEG_COUNT,
  parameter int unsigned CTL_W     = CTL_WIDTH,
  parameter int unsigned ADR_W     = ADR_WIDTH,
  parameter logic [ADR_W-1:0] ADR_VAL = ADR_MATCH,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_pin,
  input  logic             sck_pin,
  input  logic             sdi_pin,
  output logic [SEG_N-1:0] seg_data,
  output logic             bias_third,
  output logic             seg_blank,
  output logic             power_save
);
  localparam int unsigned FRAME_W = SEG_N + CTL_W;

  logic [2:0]         lvl, rise, fall;
  logic [FRAME_W-1:0] frame;
  logic               commit;
  ctl_t               ctl;

  lcdrx_sync #(.STAGES(SYNC_DEPTH), .N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({sdi_pin, sck_pin, ce_pin}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  lcdrx_frame #(.FRAME_W(FRAME_W), .ADR_W(ADR_W), .ADR_VAL(ADR_VAL)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .ce_lvl(lvl[0]), .ce_rise(rise[0]), .ce_fall(fall[0]),
    .sck_rise(rise[1]), .din(lvl[2]),
    .frame_o(frame), .commit_o(commit)
  );

  lcdrx_regs #(.SEG_N(SEG_N), .FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit), .frame_i(frame),
    .seg_o(seg_data), .ctl_o(ctl)
  );

  assign bias_third = ctl.bias3;
  assign seg_blank  = ctl.blank;
  assign power_save = ctl.save;

  // R10
  r10_commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (fall[0] && !lvl[0]));
endmodule

// File: tb/test_lcd_serial_rx.sv
`timescale 1ns/1ps
module test_lcd_serial_rx;
  typedef struct packed {
    logic [7:0] adr;
    int         nbits;
    int         seed;
    logic       idle_hi;
    int         abort_at;
    int         req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h41, 160,  3, 1'b0, -1, 5},
    '{8'h41, 160,  5, 1'b1, -1, 8},
    '{8'h42, 160,  9, 1'b0, -1, 3},
    '{8'h41, 150, 11, 1'b0, -1, 6},
    '{8'h41, 126, 13, 1'b1, -1, 6},
    '{8'h41,  41,  7, 1'b0, -1, 6},
    '{8'h41, 170, 17, 1'b0, -1, 7},
    '{8'h41, 160, 21, 1'b0,  5, 4},
    '{8'h82, 160, 23, 1'b0, -1, 2},
    '{8'h41,   0,  1, 1'b1, -1, 6},
    '{8'h41, 160, 29, 1'b1,  0, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [155:0] seg_data;
  logic bias_third, seg_blank, power_save;

  int checks = 0, misses = 0;
  logic [159:0] exp_img = '0;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_serial_rx i_lcd_serial_rx (
    .clk(clk), .rst_n(rst_n), .ce_pin(ce), .sck_pin(sck), .sdi_pin(sdi),
    .seg_data(seg_data), .bias_third(bias_third),
    .seg_blank(seg_blank), .power_save(power_save)
  );

  function automatic string tag(int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic logic pb(int seed, int i);
    return logic'(((i * seed + seed + (i >> 2)) >> 1) & 1);
  endfunction

  task automatic check(string req);
    logic [159:0] act = {1'b0, power_save, seg_blank, bias_third, seg_data};
    checks++;
    if (act !== exp_img) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_img);
    end
  endtask

  task automatic send_bit(logic b);
    sck = 1'b0; sdi = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(vec_t v);
    int na = (v.abort_at >= 0) ? v.abort_at : 8;
    logic [159:0] img = '0;
    sck = v.idle_hi;
    repeat (4) @(negedge clk);
    ce = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < na; i++) send_bit(v.adr[i]);
    if (v.abort_at < 0)
      for (int i = 0; i < v.nbits; i++) begin
        send_bit(pb(v.seed, i));
        if (i == v.nbits / 2) check("R9 mid-transfer hold");
      end
    if (!v.idle_hi) begin sck = 1'b0; repeat (4) @(negedge clk); end
    // expected image built independently: last bit lands in the top slot
    for (int i = v.nbits - 1, p = 159; i >= 0 && p >= 0; i--, p--) img[p] = pb(v.seed, i);
    img[159] = 1'b0;
    if (v.adr == 8'h41 && v.abort_at < 0) exp_img = img;
    ce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tag(v.req), "/R10 after CE fall"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release");
    for (int k = 0; k < NV; k++) run(VECS[k]);
    // R1: reset after traffic clears all outputs
    rst_n = 1'b0;
    exp_img = '0;
    repeat (2) @(negedge clk);
    check("R1 reset after traffic");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule